// File: doc/BRIEF.md
# Multistage 64x Audio Interpolator

This block raises the sample rate of an 18-bit signed audio stream by 64 in three steps, all clocked by one fast clock. A sharp halfband lowpass doubles the rate and suppresses the first image band. A shorter, gentler halfband doubles the rate again. A zero-order hold then presents each result for sixteen consecutive output slots. The block makes its own rate strobes from one set of nested counters. It asks for a new input sample with a base-rate tick, and it qualifies every oversampled output word with a strobe.

Both halfband stages run in polyphase form. On one phase the stage evaluates a symmetric FIR over its odd taps, pre-adding mirrored pairs so that only one multiply is needed per pair. On the other phase it passes a delayed input sample through unchanged, since the centre tap is the only nonzero tap on that phase. Each filter result is rounded and clamped back to 18 bits. The parameter `CLK_PER_OUT` sets how many fast clocks separate output words. With 3.072 MHz output words and a 48 kHz input, it is the fast clock frequency divided by 3.072 MHz.

Top module: `audio_interp64`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `pcm_out` becomes 0, `out_stb` becomes 0 and every delay line clears. Output words that depend only on pre-reset history are 0.
- R2: `out_stb` is high for exactly one cycle in every `CLK_PER_OUT` cycles. `smp_tick` is high for exactly one cycle in every 64*`CLK_PER_OUT` cycles. The first high cycle of each comes right after reset is released.
- R3: Number the samples captured on the ticks u[0], u[1], and so on, and let s1[k]=u[k-1], with any negative index read as 0. The first stage gives, in order, z1[2k] = R(sum over i=0..5 of g1[i]*s1[k-1-i]) and z1[2k+1] = s1[k-3], with g1 = {12,-66,566,566,-66,12}.
- R4: Let s2[j]=z1[j-1]. The second stage gives z2[2j] = R(sum over i=0..3 of g2[i]*s2[j-1-i]) and z2[2j+1] = s2[j-2], with g2 = {-32,544,544,-32}.
- R5: Number the output strobes n from 0 after reset. Output word n equals z2[(n-1)/16] for n>=1, and 0 for n=0, so each second-stage value is repeated 16 times. `pcm_out` changes only in a cycle where `out_stb` is high.
- R6: R(a) adds 512, shifts right arithmetically by 10, and clamps the result to [-131072, 131071]. An input that matches the sign pattern of the taps drives the output to the positive limit.
- R7: A constant input x, held long enough, gives an output of exactly x. This holds at both ends of the range.
- R8: `pcm_in` is captured at the clock edge that ends the `smp_tick` cycle. Output word 64k+193 is the first one that depends on u[k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pcm_in | input | 18 | Signed base-rate sample; must be valid during the `smp_tick` cycle |
| smp_tick | output | 1 | Base-rate request; `pcm_in` is captured at the end of this cycle |
| pcm_out | output | 18 | Signed oversampled output word |
| out_stb | output | 1 | Marks the cycle in which a new output word is presented |

## Verification
The bench builds the block with `CLK_PER_OUT` = 2 and the default repeat factor of 16. This gives a 128-clock base period, so 120 input samples, spanning several distinct segments, fit in about fifteen thousand cycles. At that size the bench checks every output word against the stream equations. The segments are a step from silence that exposes the latency, positive and negative full-scale DC, a sign pattern that forces the clamp, and seeded random samples. The narrow two-clock spacing of the output strobes also puts the hold-between-strobes property under constant test.

// File: rtl/interp_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and coefficient storage for the interpolator.
// Assumes coefficients are scaled by 2**COEF_FRAC and listed outer to inner
// for one half of each symmetric odd-tap set.
package interp_pkg;
    localparam int COEF_FRAC = 10;
    localparam int COEF_W    = 12;
    localparam int HB1_HALF  = 3;
    localparam int HB2_HALF  = 2;

    // Return one half-side coefficient of the selected halfband stage.
    function automatic int hb_coef(input int sel, input int idx);
        int c;
        c = 0;
        if (sel == 1) begin
            case (idx)
                0: c = 12;
                1: c = -66;
                2: c = 566;
                default: c = 0;
            endcase
        end else begin
            case (idx)
                0: c = -32;
                1: c = 544;
                default: c = 0;
            endcase
        end
        return c;
    endfunction
endpackage

// File: rtl/interp_rate_gen.sv
`timescale 1ns/1ps
// Module: interp_rate_gen
// Produces the 64x, 4x, 2x and 1x strobes from nested free-running counters.
// Assumes CLK_PER_OUT >= 1 and REPEAT >= 2. Every strobe is high in the cycle
// where all inner counters are zero, so the slower strobes coincide with faster ones.
module interp_rate_gen #(
    parameter int CLK_PER_OUT = 16,
    parameter int REPEAT      = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic t_out,
    output logic t_quad,
    output logic t_dbl,
    output logic t_base
);
    localparam int OW = (CLK_PER_OUT > 1) ? $clog2(CLK_PER_OUT) : 1;
    localparam int RW = (REPEAT > 1) ? $clog2(REPEAT) : 1;
    localparam logic [OW-1:0] O_LAST = OW'(CLK_PER_OUT - 1);
    localparam logic [RW-1:0] R_LAST = RW'(REPEAT - 1);

    logic [OW-1:0] c_out;
    logic [RW-1:0] c_rep;
    logic [1:0]    c_q;

    // Advance the clock-per-word, repeat and quarter counters as one chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_out <= '0;
            c_rep <= '0;
            c_q   <= '0;
        end else if (c_out == O_LAST) begin
            c_out <= '0;
            if (c_rep == R_LAST) begin
                c_rep <= '0;
                c_q   <= c_q + 2'd1;
            end else begin
                c_rep <= c_rep + RW'(1);
            end
        end else begin
            c_out <= c_out + OW'(1);
        end
    end

    // Decode the four strobes from the counter state.
    always_comb begin
        t_out  = (c_out == '0);
        t_quad = t_out && (c_rep == '0);
        t_dbl  = t_quad && !c_q[0];
        t_base = t_quad && (c_q == 2'd0);
    end

    // R2: the base tick never lasts two cycles.
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        t_base |=> !t_base);
endmodule

// File: rtl/interp_halfband.sv
`timescale 1ns/1ps
// Module: interp_halfband
// Two-phase polyphase halfband interpolator. The even phase shifts din into the
// delay line and outputs the rounded, saturated odd-tap FIR over the line held
// before the shift. The odd phase outputs line[HALF] unchanged (centre tap).
// Assumes stb arrives at twice the rate of the upstream stage.
module interp_halfband #(
    parameter int DATA_W = 18,
    parameter int HALF   = 3,
    parameter int SEL    = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stb,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] dout
);
    import interp_pkg::*;

    localparam int TAPS  = 2 * HALF;
    localparam int PRE_W = DATA_W + 1;
    localparam int PRD_W = PRE_W + COEF_W;
    localparam int ACC_W = PRD_W + $clog2(HALF) + 1;
    localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (COEF_FRAC - 1);

    logic signed [DATA_W-1:0] line [TAPS];
    logic signed [PRD_W-1:0]  prod [HALF];
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  rsh;
    logic signed [DATA_W-1:0] fir_q;
    logic                     phase;

    // One pre-added mirrored pair and its multiply per half-side coefficient.
    for (genvar p = 0; p < HALF; p++) begin : g_pair
        localparam logic signed [COEF_W-1:0] CO = COEF_W'(hb_coef(SEL, p));
        logic signed [PRE_W-1:0] pre;
        always_comb begin
            pre     = {line[p][DATA_W-1], line[p]} + {line[TAPS-1-p][DATA_W-1], line[TAPS-1-p]};
            prod[p] = pre * CO;
        end
    end

    // Sum the pair products, round half up, and clamp to the data width.
    always_comb begin
        acc = '0;
        for (int i = 0; i < HALF; i++) begin
            acc = acc + ACC_W'(prod[i]);
        end
        rsh = (acc + RND) >>> COEF_FRAC;
        if (rsh > MAXV) begin
            fir_q = MAXV[DATA_W-1:0];
        end else if (rsh < MINV) begin
            fir_q = MINV[DATA_W-1:0];
        end else begin
            fir_q = rsh[DATA_W-1:0];
        end
    end

    // Alternate between the FIR phase (with shift) and the centre-tap phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
            dout  <= '0;
            for (int i = 0; i < TAPS; i++) begin
                line[i] <= '0;
            end
        end else if (stb) begin
            phase <= ~phase;
            if (!phase) begin
                dout    <= fir_q;
                line[0] <= din;
                for (int i = 1; i < TAPS; i++) begin
                    line[i] <= line[i-1];
                end
            end else begin
                dout <= line[HALF];
            end
        end
    end

    // R3, R4: a stage output moves only on its own strobe.
    assert_hb_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(dout));
endmodule

// File: rtl/interp_zoh.sv
`timescale 1ns/1ps
// Module: interp_zoh
// Sample-repeat stage. It copies the second-stage output on every 64x strobe
// and flags the new word for one cycle. The repeat count comes from the strobe
// ratio, so no counter is needed here.
module interp_zoh #(
    parameter int DATA_W = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stb,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] dout,
    output logic                     dval
);
    // Load the held word and raise the valid flag for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            dval <= 1'b0;
        end else begin
            dval <= stb;
            if (stb) begin
                dout <= din;
            end
        end
    end

    // R5: the output word is held between strobes.
    assert_zoh_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(dout));
endmodule

// File: rtl/audio_interp64.sv
`timescale 1ns/1ps
// Module: audio_interp64
// Top of the 64x interpolator. It captures the input on the base tick and chains
// the sharp halfband, the relaxed halfband and the zero-order hold. Every stage
// reads the registered output of the stage before it.
// Assumes pcm_in is valid during every smp_tick cycle.
module audio_interp64 #(
    parameter int DATA_W      = 18,
    parameter int CLK_PER_OUT = 16,
    parameter int REPEAT      = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] pcm_in,
    output logic                     smp_tick,
    output logic signed [DATA_W-1:0] pcm_out,
    output logic                     out_stb
);
    import interp_pkg::*;

    logic t_out, t_quad, t_dbl, t_base;
    logic signed [DATA_W-1:0] x_in;
    logic signed [DATA_W-1:0] y1;
    logic signed [DATA_W-1:0] y2;

    interp_rate_gen #(.CLK_PER_OUT(CLK_PER_OUT), .REPEAT(REPEAT)) u_rates (
        .clk(clk), .rst_n(rst_n),
        .t_out(t_out), .t_quad(t_quad), .t_dbl(t_dbl), .t_base(t_base)
    );

    assign smp_tick = t_base;

    // Capture the base-rate input sample at the end of the tick cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_in <= '0;
        end else if (t_base) begin
            x_in <= pcm_in;
        end
    end

    interp_halfband #(.DATA_W(DATA_W), .HALF(HB1_HALF), .SEL(1)) u_hb_sharp (
        .clk(clk), .rst_n(rst_n), .stb(t_dbl), .din(x_in), .dout(y1)
    );

    interp_halfband #(.DATA_W(DATA_W), .HALF(HB2_HALF), .SEL(2)) u_hb_soft (
        .clk(clk), .rst_n(rst_n), .stb(t_quad), .din(y1), .dout(y2)
    );

    interp_zoh #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .stb(t_out), .din(y2), .dout(pcm_out), .dval(out_stb)
    );

    // R1: reset clears the output word and its strobe.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pcm_out == '0 && !out_stb));

    // R2: with more than one clock per word, the strobe is a single-cycle pulse.
    if (CLK_PER_OUT > 1) begin : g_stb_chk
        assert_stb_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_stb |=> !out_stb);
    end
endmodule

// File: tb/audio_interp64_bench.sv
`timescale 1ns/1ps
module audio_interp64_bench;
    localparam int C  = 2;
    localparam int N  = 120;
    localparam int PMAX = 131071;
    localparam int PMIN = -131072;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [17:0] pcm_in = '0;
    logic smp_tick;
    logic signed [17:0] pcm_out;
    logic out_stb;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int u  [N];
    int z1 [2*N];
    int z2 [4*N];
    int g1 [6] = '{12, -66, 566, 566, -66, 12};
    int g2 [4] = '{-32, 544, 544, -32};
    bit saw_max = 0;

    audio_interp64 #(.DATA_W(18), .CLK_PER_OUT(C), .REPEAT(16)) u_audio_interp64 (
        .clk(clk), .rst_n(rst_n), .pcm_in(pcm_in),
        .smp_tick(smp_tick), .pcm_out(pcm_out), .out_stb(out_stb)
    );

    always #2 clk = ~clk;

    function automatic int rq(input longint a);
        longint r;
        r = (a + 512) >>> 10;
        if (r > PMAX) r = PMAX;
        if (r < PMIN) r = PMIN;
        return int'(r);
    endfunction

    function automatic int s1(input int j);
        return (j - 1 >= 0 && j - 1 < N) ? u[j-1] : 0;
    endfunction

    function automatic int s2(input int j);
        return (j - 1 >= 0 && j - 1 < 2*N) ? z1[j-1] : 0;
    endfunction

    function automatic int expect_out(input int n);
        return (n == 0) ? 0 : z2[(n-1)/16];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build_model();
        for (int k = 0; k < N; k++) begin
            longint a;
            a = 0;
            for (int i = 0; i < 6; i++) a += longint'(g1[i]) * s1(k - 1 - i);
            z1[2*k]   = rq(a);
            z1[2*k+1] = s1(k - 3);
        end
        for (int j = 0; j < 2*N; j++) begin
            longint a;
            a = 0;
            for (int i = 0; i < 4; i++) a += longint'(g2[i]) * s2(j - 1 - i);
            z2[2*j]   = rq(a);
            z2[2*j+1] = s2(j - 2);
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        for (int k = 0; k < N; k++) begin
            if (k < 10)       u[k] = 0;
            else if (k < 30)  u[k] = 100000;
            else if (k < 60)  u[k] = int'($urandom_range(262143, 0)) - 131072;
            else if (k < 90)  u[k] = ((k % 3) == 1) ? PMIN : PMAX;
            else if (k < 105) u[k] = PMIN;
            else              u[k] = int'($urandom_range(262143, 0)) - 131072;
        end
        build_model();
        pcm_in = 18'(u[0]);

        // R1: state while reset is held.
        repeat (3) @(negedge clk);
        check(pcm_out == 0 && out_stb == 0, "R1 reset", int'(pcm_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        fork
            // Driver: present the next sample right after each capture edge (R8).
            begin
                for (int k = 0; k < N - 1; k++) begin
                    while (!smp_tick) @(negedge clk);
                    @(posedge clk);
                    #1 pcm_in = 18'(u[k+1]);
                    @(negedge clk);
                end
            end
            // Monitor: every output word against the model (R3/R4/R5/R6).
            begin
                int n;
                int last;
                n = 0;
                last = 0;
                while (n < 64 * N) begin
                    @(negedge clk);
                    if (out_stb) begin
                        check(int'(pcm_out) == expect_out(n), "R3/R4/R5 word", int'(pcm_out), expect_out(n));
                        if (n <= 64 * 10 + 192)
                            check(pcm_out == 0, "R8 before step", int'(pcm_out), 0);
                        if (n == 64 * 10 + 193)
                            check(pcm_out != 0, "R8 first response", int'(pcm_out), expect_out(n));
                        if (n == 64 * 29 + 150)
                            check(pcm_out == 100000, "R7 positive DC", int'(pcm_out), 100000);
                        if (n == 64 * 104 + 150)
                            check(pcm_out == PMIN, "R7 negative full-scale DC", int'(pcm_out), PMIN);
                        if (n >= 64 * 60 && n < 64 * 90 && pcm_out == PMAX) saw_max = 1;
                        last = int'(pcm_out);
                        n++;
                    end else begin
                        check(int'(pcm_out) == last, "R5 hold", int'(pcm_out), last);
                    end
                end
                check(saw_max, "R6 clamp reached", int'(saw_max), 1);
            end
            // Strobe spacing (R2).
            begin
                int cyc;
                int t_last;
                int s_last;
                int nt;
                int ns;
                cyc = 0; t_last = -1; s_last = -1; nt = 0; ns = 0;
                while (nt < 5 || ns < 10) begin
                    @(negedge clk);
                    cyc++;
                    if (smp_tick) begin
                        if (t_last >= 0 && nt < 5) begin
                            check(cyc - t_last == 64 * C, "R2 tick period", cyc - t_last, 64 * C);
                            nt++;
                        end
                        t_last = cyc;
                    end
                    if (out_stb) begin
                        if (s_last >= 0 && ns < 10) begin
                            check(cyc - s_last == C, "R2 strobe period", cyc - s_last, C);
                            ns++;
                        end
                        s_last = cyc;
                    end
                end
            end
        join

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule